// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block generates the raster timing for a parallel RGB TFT panel. It drives the horizontal sync, vertical sync and data-enable pins, and it passes the pixel clock through with a selectable phase. It also gives downstream pixel logic the zero-based position of the current pixel, a flag that marks the visible window, and polarity-free copies of both sync states. Horizontal widths are counted in pixel clocks and vertical heights in whole lines. Each axis has four programmable segments in fixed order: sync, back porch, active and front porch.

A one-cycle pulse on `cfg_load` captures a new set of widths and polarities, and the raster restarts from the first pixel of the first line. After reset the block holds a 240x320 portrait timing with small porches, so the panel pins are valid at once. A one-cycle strobe marks the start of the first line after the visible area. Software can use it as the safe point to swap frame buffers.

Top module: `rgb_panel_timing`

## Requirements
- R1: After reset the timing is horizontal sync 10, back porch 20, active 240, front porch 10 clocks, and vertical sync 2, back porch 2, active 320, front porch 4 lines. The polarity code is 0 and the raster starts at line 0, clock 0.
- R2: A line lasts h_sync+h_bp+h_act+h_fp clocks. The horizontal sync is logically asserted during the first h_sync clocks of every line.
- R3: A frame lasts v_sync+v_bp+v_act+v_fp lines. The vertical sync is logically asserted for the whole of the first v_sync lines.
- R4: `active_o` is high only when the clock index within the line lies in [h_sync+h_bp, h_sync+h_bp+h_act) and the line index lies in [v_sync+v_bp, v_sync+v_bp+v_act). `x_o`/`y_o` give the zero-based offset within that window, and they read 0 outside it.
- R5: Polarity bit 0 selects the hsync pin and bit 1 the vsync pin. A value of 0 drives the pin low when the sync is asserted, and a value of 1 drives it high.
- R6: Polarity bit 2 sets the enable pin. With 0 the pin is low during active pixels and high otherwise. With 1 the pin follows `active_o`.
- R7: Polarity bit 3 set to 0 makes `pclk_o` follow `clk`. Set to 1, it gives the inverse of `clk`.
- R8: `stat_hsync_o` and `stat_vsync_o` are high exactly when the respective sync is logically asserted, whatever the polarity bits hold.
- R9: `vblank_o` pulses for one clock on clock 0 of line v_sync+v_bp+v_act. It is never high during active pixels. This needs v_fp of at least 1 and a line length of at least 2.
- R10: A `cfg_load` pulse captures every width and the polarity code on the same edge. From the next cycle the raster runs from line 0, clock 0 under the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture the configuration and restart the raster |
| cfg_h_sync | input | HW | Horizontal sync width in clocks |
| cfg_h_bp | input | HW | Horizontal back porch in clocks |
| cfg_h_act | input | HW | Active pixels per line |
| cfg_h_fp | input | HW | Horizontal front porch in clocks |
| cfg_v_sync | input | VW | Vertical sync height in lines |
| cfg_v_bp | input | VW | Vertical back porch in lines |
| cfg_v_act | input | VW | Active lines per frame |
| cfg_v_fp | input | VW | Vertical front porch in lines |
| cfg_pol | input | 4 | Polarity code: hsync, vsync, enable, pixel clock (bits 0..3) |
| pclk_o | output | 1 | Pixel clock to the panel |
| hsync_o | output | 1 | Horizontal sync pin |
| vsync_o | output | 1 | Vertical sync pin |
| de_o | output | 1 | Data-enable pin |
| active_o | output | 1 | Current pixel lies in the visible window |
| x_o | output | HW | Pixel column within the window |
| y_o | output | VW | Pixel row within the window |
| stat_hsync_o | output | 1 | Logical hsync state |
| stat_vsync_o | output | 1 | Logical vsync state |
| vblank_o | output | 1 | Strobe at the start of the first line after the active area |

## Verification
The vertical-blanking strobe always falls on clock 0 of a line, which is also the first clock of horizontal sync. The strobe and the start of a sync pulse therefore coincide, and a configuration load can be forced into that same cycle. The bench waits for the strobe and checks that the logical hsync is high alongside it. It then pulses `cfg_load` in exactly that cycle and checks that the next cycle is line 0, clock 0 of the new timing, with no second strobe. A cycle-by-cycle reference model run over complete frames judges every other cycle.

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing #(
  parameter int HW        = 12,
  parameter int VW        = 12,
  parameter int DEF_H_SYN = 10,
  parameter int DEF_H_BP  = 20,
  parameter int DEF_H_ACT = 240,
  parameter int DEF_H_FP  = 10,
  parameter int DEF_V_SYN = 2,
  parameter int DEF_V_BP  = 2,
  parameter int DEF_V_ACT = 320,
  parameter int DEF_V_FP  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [HW-1:0] cfg_h_sync,
  input  logic [HW-1:0] cfg_h_bp,
  input  logic [HW-1:0] cfg_h_act,
  input  logic [HW-1:0] cfg_h_fp,
  input  logic [VW-1:0] cfg_v_sync,
  input  logic [VW-1:0] cfg_v_bp,
  input  logic [VW-1:0] cfg_v_act,
  input  logic [VW-1:0] cfg_v_fp,
  input  logic [3:0]    cfg_pol,
  output logic          pclk_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          active_o,
  output logic [HW-1:0] x_o,
  output logic [VW-1:0] y_o,
  output logic          stat_hsync_o,
  output logic          stat_vsync_o,
  output logic          vblank_o
);
  localparam int HT = HW + 2;
  localparam int VT = VW + 2;

  logic [HW-1:0] h_syn, h_bp, h_act, h_fp;
  logic [VW-1:0] v_syn, v_bp, v_act, v_fp;
  logic [3:0]    pol;
  logic [HT-1:0] hc;
  logic [VT-1:0] vc;

  wire [HT-1:0] h_win0 = HT'(h_syn) + HT'(h_bp);
  wire [HT-1:0] h_win1 = h_win0 + HT'(h_act);
  wire [HT-1:0] h_tot  = h_win1 + HT'(h_fp);
  wire [VT-1:0] v_win0 = VT'(v_syn) + VT'(v_bp);
  wire [VT-1:0] v_win1 = v_win0 + VT'(v_act);
  wire [VT-1:0] v_tot  = v_win1 + VT'(v_fp);

  wire line_end  = hc >= h_tot - HT'(1);
  wire frame_end = vc >= v_tot - VT'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_syn <= HW'(DEF_H_SYN);
      h_bp  <= HW'(DEF_H_BP);
      h_act <= HW'(DEF_H_ACT);
      h_fp  <= HW'(DEF_H_FP);
      v_syn <= VW'(DEF_V_SYN);
      v_bp  <= VW'(DEF_V_BP);
      v_act <= VW'(DEF_V_ACT);
      v_fp  <= VW'(DEF_V_FP);
      pol   <= '0;
      hc    <= '0;
      vc    <= '0;
    end else if (cfg_load) begin
      h_syn <= cfg_h_sync;
      h_bp  <= cfg_h_bp;
      h_act <= cfg_h_act;
      h_fp  <= cfg_h_fp;
      v_syn <= cfg_v_sync;
      v_bp  <= cfg_v_bp;
      v_act <= cfg_v_act;
      v_fp  <= cfg_v_fp;
      pol   <= cfg_pol;
      hc    <= '0;
      vc    <= '0;
    end else if (line_end) begin
      hc <= '0;
      vc <= frame_end ? '0 : vc + VT'(1);
    end else begin
      hc <= hc + HT'(1);
    end
  end

  wire hs_on = hc < HT'(h_syn);
  wire vs_on = vc < VT'(v_syn);
  wire h_in  = (hc >= h_win0) && (hc < h_win1);
  wire v_in  = (vc >= v_win0) && (vc < v_win1);

  assign active_o     = h_in && v_in;
  assign x_o          = active_o ? HW'(hc - h_win0) : '0;
  assign y_o          = active_o ? VW'(vc - v_win0) : '0;
  assign stat_hsync_o = hs_on;
  assign stat_vsync_o = vs_on;
  assign hsync_o      = pol[0] ? hs_on : ~hs_on;
  assign vsync_o      = pol[1] ? vs_on : ~vs_on;
  assign de_o         = pol[2] ? active_o : ~active_o;
  assign pclk_o       = clk ^ pol[3];
  assign vblank_o     = (hc == '0) && (vc == v_win1);
endmodule

// File: rtl/rgb_panel_timing_chk.sv
module rgb_panel_timing_chk #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          active_o,
  input logic [HW-1:0] x_o,
  input logic [VW-1:0] y_o,
  input logic          stat_hsync_o,
  input logic          vblank_o
);
  AST_ACTIVE_OUTSIDE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |-> !stat_hsync_o); // R4
  AST_X_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o) && x_o != '0) |-> x_o == $past(x_o) + HW'(1)); // R4
  AST_Y_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && $past(active_o) && x_o != '0) |-> y_o == $past(y_o)); // R4
  AST_VBLANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |-> !active_o); // R9
  AST_VBLANK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_o |=> !vblank_o); // R9
  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!vblank_o || y_o == '0) && x_o == '0); // R10
endmodule

bind rgb_panel_timing rgb_panel_timing_chk #(.HW(HW), .VW(VW)) chk_i (.*);

// File: tb/rgb_panel_timing_tb_top.sv
module rgb_panel_timing_tb_top;
  localparam int HW = 12;
  localparam int VW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic cfg_load = 0;
  logic [HW-1:0] cfg_h_sync = '0, cfg_h_bp = '0, cfg_h_act = '0, cfg_h_fp = '0;
  logic [VW-1:0] cfg_v_sync = '0, cfg_v_bp = '0, cfg_v_act = '0, cfg_v_fp = '0;
  logic [3:0] cfg_pol = '0;
  logic pclk_o, hsync_o, vsync_o, de_o, active_o, stat_hsync_o, stat_vsync_o, vblank_o;
  logic [HW-1:0] x_o;
  logic [VW-1:0] y_o;

  always #10 clk = ~clk;

  rgb_panel_timing #(.HW(HW), .VW(VW)) dut_i (.*);

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int mhs, mhb, mha, mhf, mvs, mvb, mva, mvf, mpol;
  int n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare_now();
    int ht, vt, hc, vc, a0, b0;
    bit hs, vs, act, vb;
    ht = mhs + mhb + mha + mhf;
    vt = mvs + mvb + mva + mvf;
    hc = n % ht;
    vc = (n / ht) % vt;
    a0 = mhs + mhb;
    b0 = mvs + mvb;
    hs = hc < mhs;
    vs = vc < mvs;
    act = (hc >= a0) && (hc < a0 + mha) && (vc >= b0) && (vc < b0 + mva);
    vb = (hc == 0) && (vc == b0 + mva);
    check(stat_hsync_o == hs, "R2 stat_hsync", stat_hsync_o, hs);
    check(stat_vsync_o == vs, "R3 stat_vsync", stat_vsync_o, vs);
    check(hsync_o == (mpol[0] ? hs : !hs), "R5 hsync pin", hsync_o, mpol[0] ? hs : !hs);
    check(vsync_o == (mpol[1] ? vs : !vs), "R5 vsync pin", vsync_o, mpol[1] ? vs : !vs);
    check(de_o == (mpol[2] ? act : !act), "R6 enable pin", de_o, mpol[2] ? act : !act);
    check(active_o == act, "R4 active", active_o, act);
    check(int'(x_o) == (act ? hc - a0 : 0), "R4 x", x_o, act ? hc - a0 : 0);
    check(int'(y_o) == (act ? vc - b0 : 0), "R4 y", y_o, act ? vc - b0 : 0);
    check(vblank_o == vb, "R9 vblank", vblank_o, vb);
    check(pclk_o == mpol[3], "R7 pclk low phase", pclk_o, mpol[3]);
    check(stat_hsync_o == hs && stat_vsync_o == vs, "R8 status", {stat_hsync_o, stat_vsync_o}, {hs, vs});
  endtask

  task automatic run_model(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      compare_now();
      @(negedge clk);
      n++;
    end
  endtask

  task automatic load(input int hs, hb, ha, hf, vs, vb, va, vf, pl);
    cfg_h_sync = HW'(hs); cfg_h_bp = HW'(hb); cfg_h_act = HW'(ha); cfg_h_fp = HW'(hf);
    cfg_v_sync = VW'(vs); cfg_v_bp = VW'(vb); cfg_v_act = VW'(va); cfg_v_fp = VW'(vf);
    cfg_pol = 4'(pl);
    cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
    mhs = hs; mhb = hb; mha = ha; mhf = hf;
    mvs = vs; mvb = vb; mva = va; mvf = vf; mpol = pl;
    n = 0;
  endtask

  task automatic t_reset_default();
    mhs = 10; mhb = 20; mha = 240; mhf = 10;
    mvs = 2; mvb = 2; mva = 320; mvf = 4; mpol = 0;
    n = 0;
    check(hsync_o == 0 && vsync_o == 0 && de_o == 1 && active_o == 0, "R1 reset pins",
          {hsync_o, vsync_o, de_o, active_o}, 4'b0010);
    run_model(280 * 328 + 300);
  endtask

  task automatic t_small_frames();
    load(2, 3, 5, 2, 1, 2, 3, 2, 0);
    run_model(12 * 8 * 2 + 5);
  endtask

  task automatic t_all_inverted();
    load(3, 1, 4, 1, 2, 1, 2, 1, 15);
    check(pclk_o == 1, "R7 pclk inverted", pclk_o, 1);
    run_model(9 * 6 * 2 + 3);
  endtask

  task automatic t_mixed_pol();
    load(1, 0, 6, 3, 1, 0, 4, 1, 5);
    run_model(10 * 6 * 2);
    load(4, 2, 3, 1, 3, 1, 2, 2, 10);
    run_model(10 * 8 * 2);
  endtask

  task automatic t_load_mid_frame();
    load(2, 3, 5, 2, 1, 2, 3, 2, 0);
    run_model(37);
    load(1, 1, 3, 1, 1, 1, 2, 1, 4);
    check(stat_hsync_o == 1 && stat_vsync_o == 1, "R10 restart at origin",
          {stat_hsync_o, stat_vsync_o}, 3);
    run_model(6 * 5 * 2);
  endtask

  task automatic t_vblank_collision();
    int guard;
    load(2, 1, 4, 1, 1, 1, 3, 2, 0);
    guard = 0;
    while (!vblank_o && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(guard == 8 * 5, "R9 strobe cycle", guard, 8 * 5);
    check(stat_hsync_o == 1, "R9 strobe with hsync start", stat_hsync_o, 1);
    load(3, 2, 4, 2, 2, 1, 3, 1, 0);
    check(vblank_o == 0, "R10 load over strobe", vblank_o, 0);
    run_model(11 * 7 * 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_default();
    t_small_frames();
    t_all_inverted();
    t_mixed_pol();
    t_load_mid_frame();
    t_vblank_collision();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule